// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block gathers received characters from sixteen asynchronous serial line receivers into one shared first-in first-out store. Each stored word carries the character, the number of the line it came from, and its error flags. A host drains the store through a single receive register. The top bit of the receive word is set only when the word holds a character, so software can keep reading for as long as the value is negative as a signed 16-bit number.

Each line offers a character with a one-cycle strobe that carries its parity and framing flags. A one-deep capture slot per line holds the character until a fixed-priority arbiter moves it into the store. The arbiter moves one character per cycle, lowest line number first. A control/status register holds the interrupt enables, the interrupt flags and a master clear. A second writable register sets the fill level at which an alarm interrupt is raised.

Top module: `rx_silo`

## Requirements
- R1: After reset the receive word reads 0x0000, the control/status word reads 0x0000, the alarm level reads 0 and `irq` is low.
- R2: A receive word is laid out as follows: bit 15 is set for a valid character, bit 14 is overrun, bit 13 is framing error, bit 12 is parity error, bits 11:8 are the source line and bits 7:0 are the character.
- R3: Each read of the receive register (select 1) that returns a valid word removes exactly that entry, and entries come out in the order they were stored. A read of an empty store returns bit 15 clear and changes nothing.
- R4: When several capture slots hold characters in the same cycle, the characters are stored in ascending line order, one per clock.
- R5: With DEPTH entries stored, a character that reaches the store is dropped. The next character that is stored has bit 14 set, and the characters after it do not.
- R6: If a line strobes a new character while its capture slot still holds one that is not being moved that cycle, the new character replaces the old one and has bit 14 set.
- R7: Control/status bit 7 reads 1 while the store is non-empty. Bit 6 is a read/write receive interrupt enable. `irq` is high whenever both are set.
- R8: The alarm level is read and written at select 2. Control/status bit 14 becomes set once the fill level is at least a nonzero alarm level, and it stays set until a control/status write with bit 14 clear. Bit 12 is its read/write enable, and `irq` is high whenever bit 14 and bit 12 are both set.
- R9: Writing control/status bit 11 empties the store and the capture slots and clears the enables, the flags and the alarm level. The other bits of that write are ignored, and bit 11 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 16 | Per-line character strobe |
| line_data | input | 128 | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | 16 | Per-line parity error flag, valid with strobe |
| line_ferr | input | 16 | Per-line framing error / break flag, valid with strobe |
| reg_sel | input | 2 | Register select: 0 control/status, 1 receive, 2 alarm level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on select 1) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, combinational |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the store to exactly DEPTH entries and sends two more characters. A design that dropped at the wrong count, or that failed to mark or clear the overrun flag, would return an extra word or a wrongly flagged one. Sixteen lines strobing at once, and then again one cycle later, exercise ascending order and slot replacement. A design with reversed priority or unflagged replacement would return the words in a different order or with different tags. The alarm is tested one entry below and at the level, and again after the store is drained. This catches an off-by-one compare or a flag that is not sticky. Master clear is issued with other enable bits set in the same write, to catch a design that lets those bits through.

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  line_valid,
  input  logic [127:0] line_data,
  input  logic [15:0]  line_perr,
  input  logic [15:0]  line_ferr,
  input  logic [1:0]   reg_sel,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [15:0]  reg_wdata,
  output logic [15:0]  reg_rdata,
  output logic         irq
);
  localparam int NL = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [NL-1:0] pend, pend_ovr, pend_pe, pend_fe;
  logic [7:0]    pend_d [NL];
  logic [14:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, thr;
  logic          rie, aie, alarm, lost;

  logic          gnt_any;
  logic [3:0]    gnt;
  always_comb begin
    gnt_any = 1'b0;
    gnt = '0;
    for (int i = NL-1; i >= 0; i--)
      if (pend[i]) begin
        gnt_any = 1'b1;
        gnt = 4'(i);
      end
  end

  wire full    = cnt == CW'(DEPTH);
  wire nonempt = cnt != '0;
  wire push    = gnt_any && !full;
  wire drop    = gnt_any && full;
  wire pop     = reg_rd && reg_sel == 2'd1 && nonempt;
  wire csr_wr  = reg_wr && reg_sel == 2'd0;
  wire mc      = csr_wr && reg_wdata[11];
  wire hit     = thr != '0 && cnt >= thr;
  wire [14:0] push_w = {pend_ovr[gnt] | lost, pend_fe[gnt], pend_pe[gnt], gnt, pend_d[gnt]};

  for (genvar i = 0; i < NL; i++) begin : g_slot
    wire take = gnt_any && gnt == 4'(i);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pend[i] <= 1'b0; pend_ovr[i] <= 1'b0; pend_pe[i] <= 1'b0;
        pend_fe[i] <= 1'b0; pend_d[i] <= '0;
      end else if (mc) begin
        pend[i] <= 1'b0; pend_ovr[i] <= 1'b0;
      end else if (line_valid[i]) begin
        pend[i]     <= 1'b1;
        pend_ovr[i] <= pend[i] && !take;
        pend_pe[i]  <= line_perr[i];
        pend_fe[i]  <= line_ferr[i];
        pend_d[i]   <= line_data[8*i +: 8];
      end else if (take) begin
        pend[i]     <= 1'b0;
      end
  end

  always_ff @(posedge clk)
    if (push && !mc) mem[wp] <= push_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; thr <= '0;
      rie <= 1'b0; aie <= 1'b0; alarm <= 1'b0; lost <= 1'b0;
    end else if (mc) begin
      wp <= '0; rp <= '0; cnt <= '0; thr <= '0;
      rie <= 1'b0; aie <= 1'b0; alarm <= 1'b0; lost <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (drop) lost <= 1'b1;
      else if (push) lost <= 1'b0;
      if (csr_wr) begin
        rie <= reg_wdata[6];
        aie <= reg_wdata[12];
      end
      if (reg_wr && reg_sel == 2'd2) thr <= reg_wdata[CW-1:0];
      alarm <= (csr_wr && !reg_wdata[14]) ? 1'b0 : (alarm | hit);
    end

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = {1'b0, alarm, 1'b0, aie, 4'b0, nonempt, rie, 6'b0};
      2'd1:    reg_rdata = nonempt ? {1'b1, mem[rp]} : 16'h0000;
      2'd2:    reg_rdata = 16'(thr);
      default: reg_rdata = 16'h0000;
    endcase

  assign irq = (nonempt && rie) || (alarm && aie);
endmodule

module rx_silo_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  cnt,
  input logic        pop,
  input logic        mc,
  input logic        rie,
  input logic        aie,
  input logic        irq,
  input logic [15:0] pend,
  input logic        gnt_any,
  input logic        csr_wr_clear,
  input logic        hit
);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 7'(DEPTH));
  p_full_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 7'(DEPTH) && !pop && !mc) |=> cnt == 7'(DEPTH));
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mc |=> (cnt == '0 && pend == '0 && !irq));
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rie && !aie) |-> !irq);
  p_one_per_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && !mc && !pop && cnt < 7'(DEPTH)) |=> cnt == $past(cnt) + 7'd1);
  p_alarm_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && aie && !mc && !csr_wr_clear) |=> irq);
endmodule

bind rx_silo rx_silo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(7'(cnt)), .pop(pop), .mc(mc),
  .rie(rie), .aie(aie), .irq(irq), .pend(pend), .gnt_any(gnt_any),
  .csr_wr_clear(csr_wr && (!reg_wdata[14] || !reg_wdata[12])), .hit(hit)
);

// File: tb/rx_silo_bench.sv
module rx_silo_bench;
  localparam int DEPTH = 64;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  line_valid = '0;
  logic [127:0] line_data = '0;
  logic [15:0]  line_perr = '0, line_ferr = '0;
  logic [1:0]   reg_sel = '0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]  reg_wdata = '0;
  logic [15:0]  reg_rdata;
  logic         irq;

  int checks = 0, fails = 0;
  logic [15:0] expq [$];

  always #4 clk = ~clk;

  rx_silo #(.DEPTH(DEPTH)) u_rx_silo (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one strobe on one line, expectation queued
  task automatic send(int ln, logic [7:0] d, logic pe, logic fe, logic ovr);
    @(negedge clk);
    line_valid = '0; line_valid[ln] = 1'b1;
    line_data[8*ln +: 8] = d; line_perr[ln] = pe; line_ferr[ln] = fe;
    expq.push_back({1'b1, ovr, fe, pe, 4'(ln), d});
    @(negedge clk); line_valid = '0; line_perr = '0; line_ferr = '0;
  endtask

  // monitor: drain the store and compare against the scoreboard
  task automatic drain(string req);
    logic [15:0] v;
    logic [15:0] e;
    for (int n = 0; n < 200; n++) begin
      rd(2'd1, v);
      if (!v[15]) break;
      e = (expq.size() > 0) ? expq.pop_front() : 16'hdead;
      check(req, v, e);
    end
    check({req, " R3 empty"}, v, 16'h0000);
    check({req, " leftover"}, 16'(expq.size()), 16'h0);
    expq.delete();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3); rst_n = 1'b1; idle(1);
    // R1
    rd(2'd1, v); check("R1 rx", v, 16'h0000);
    rd(2'd0, v); check("R1 csr", v, 16'h0000);
    rd(2'd2, v); check("R1 alarm level", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R2 R3: field layout and order
    send(5, 8'h41, 1'b0, 1'b0, 1'b0);
    send(12, 8'hc3, 1'b1, 1'b0, 1'b0);
    send(0, 8'h00, 1'b0, 1'b1, 1'b0);
    send(15, 8'h7e, 1'b1, 1'b1, 1'b0);
    idle(4);
    drain("R2/R3");

    // R4: simultaneous strobes, ascending order
    @(negedge clk);
    line_valid = 16'ha5a5;
    for (int i = 0; i < 16; i++) begin
      line_data[8*i +: 8] = 8'(8'h20 + i);
      if (line_valid[i]) expq.push_back({1'b1, 3'b000, 4'(i), 8'(8'h20 + i)});
    end
    @(negedge clk); line_valid = '0;
    idle(20);
    drain("R4");

    // R6: all lines strobe twice back to back
    @(negedge clk);
    line_valid = '1;
    for (int i = 0; i < 16; i++) line_data[8*i +: 8] = 8'(8'h40 + i);
    @(negedge clk);
    for (int i = 0; i < 16; i++) line_data[8*i +: 8] = 8'(8'h80 + i);
    @(negedge clk); line_valid = '0;
    expq.push_back({1'b1, 3'b000, 4'd0, 8'h40});
    expq.push_back({1'b1, 3'b000, 4'd0, 8'h80});
    for (int i = 1; i < 16; i++) expq.push_back({1'b1, 3'b100, 4'(i), 8'(8'h80 + i)});
    idle(24);
    drain("R6");

    // R5: fill to DEPTH, two dropped, next flagged, following clean
    for (int i = 0; i < DEPTH; i++) send(3, 8'(i), 1'b0, 1'b0, 1'b0);
    send(3, 8'hee, 1'b0, 1'b0, 1'b0); void'(expq.pop_back());
    send(4, 8'hef, 1'b0, 1'b0, 1'b0); void'(expq.pop_back());
    idle(4);
    drain("R5 full");
    send(7, 8'h55, 1'b0, 1'b0, 1'b1);
    send(7, 8'h56, 1'b0, 1'b0, 1'b0);
    idle(4);
    drain("R5 after drop");

    // R7: receive interrupt
    wr(2'd0, 16'h0040);
    rd(2'd0, v); check("R7 csr empty", v, 16'h0040);
    check("R7 irq empty", {15'b0, irq}, 16'h0);
    send(9, 8'h11, 1'b0, 1'b0, 1'b0);
    idle(3);
    rd(2'd0, v); check("R7 csr full", v, 16'h00c0);
    check("R7 irq", {15'b0, irq}, 16'h1);
    drain("R7");
    check("R7 irq drained", {15'b0, irq}, 16'h0);

    // R8: alarm level
    wr(2'd0, 16'h1000);
    wr(2'd2, 16'd4);
    rd(2'd2, v); check("R8 level", v, 16'd4);
    for (int i = 0; i < 3; i++) send(2, 8'(8'h30 + i), 1'b0, 1'b0, 1'b0);
    idle(4);
    rd(2'd0, v); check("R8 below", v, 16'h1080);
    check("R8 irq below", {15'b0, irq}, 16'h0);
    send(2, 8'h33, 1'b0, 1'b0, 1'b0);
    idle(4);
    rd(2'd0, v); check("R8 at level", v, 16'h5080);
    check("R8 irq", {15'b0, irq}, 16'h1);
    drain("R8");
    rd(2'd0, v); check("R8 sticky", v, 16'h5000);
    wr(2'd0, 16'h1000);
    idle(2);
    rd(2'd0, v); check("R8 cleared", v, 16'h1000);
    check("R8 irq cleared", {15'b0, irq}, 16'h0);

    // R9: master clear
    send(1, 8'h91, 1'b0, 1'b0, 1'b0);
    send(6, 8'h96, 1'b0, 1'b0, 1'b0);
    idle(4);
    @(negedge clk);
    line_valid = 16'h0100; line_data[8*8 +: 8] = 8'h98;
    @(negedge clk); line_valid = '0;
    wr(2'd0, 16'h1840);
    idle(3);
    rd(2'd0, v); check("R9 csr", v, 16'h0000);
    rd(2'd2, v); check("R9 level", v, 16'h0000);
    rd(2'd1, v); check("R9 rx", v, 16'h0000);
    check("R9 irq", {15'b0, irq}, 16'h0);
    expq.delete();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule